// File: doc/BRIEF.md
# Selective Bit-Manipulation Register

This block holds one N-bit accumulator word and changes it in place. On each request it applies a control pattern to the word. A bit position is set, inverted, cleared or kept according to the matching bit of the pattern. One further operation, insert, writes a new value into a chosen field of the word. It runs in two steps: a mask step first clears the field, and an OR step then merges in the new bits.

A caller raises `start` for one cycle with an operation code, a pattern `pat_b` and, for insert only, a value `val_c`. Every operation except insert finishes on the first clock edge. `done` pulses in the cycle that shows the new word. Insert keeps `busy` high for two cycles and pulses `done` once the merged word is visible. The block ignores any request that arrives while it is busy.

Top module: `bitpatch_reg`

## Requirements
- R1: A synchronous reset sets `acc` to zero, sets `busy` and `done` low, and cancels any insert in progress.
- R2: Op code 3'b000 (set) makes `acc` equal to `acc | pat_b` on the edge that accepts the request.
- R3: Op code 3'b001 (complement) makes `acc` equal to `acc ^ pat_b`, inverting only the bits where the pattern is 1.
- R4: Op code 3'b010 (clear) makes `acc` equal to `acc & ~pat_b`.
- R5: Op code 3'b011 (mask) makes `acc` equal to `acc & pat_b`, zeroing every bit where the pattern is 0.
- R6: Op code 3'b100 (clear-on-match) makes `acc` equal to `acc ^ pat_b`. A bit becomes 0 where the word and the pattern agree, and 1 where they differ.
- R7: Op code 3'b101 (insert) runs as follows. The accepting edge changes nothing in `acc` and raises `busy`. The second edge sets `acc` to `acc & pat_b`. The third edge ORs in `val_c`, drops `busy` and raises `done`. For example, 0xD8B1 with mask 0xFFF0 and value 0x000A gives 0xD8B0 and then 0xD8BA.
- R8: Insert uses the `pat_b` and `val_c` that were present on its accepting edge. Later changes to those inputs while `busy` is high have no effect on the result.
- R9: A `start` that arrives while `busy` is high is ignored. It changes neither `acc` nor the insert sequence.
- R10: Op codes 3'b110 and 3'b111 leave `acc` unchanged and still pulse `done`.
- R11: Every operation other than insert raises `done` for exactly one cycle after the accepting edge, and `busy` stays low throughout. `acc` holds its value whenever no request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe, taken when not busy |
| op_code | input | 3 | Operation select |
| pat_b | input | WIDTH | Control pattern, and the mask for insert |
| val_c | input | WIDTH | New bits for insert |
| acc | output | WIDTH | Accumulator word |
| busy | output | 1 | Insert sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle, each single-step result against the word and pattern from the cycle before. They also check the insert mask and merge values two and three edges after acceptance, and that `busy` and `done` are never high together. The sequencer's assertions confirm that a busy-time request cannot disturb the step order. Only the bench scenarios show the full chained value history across all op codes. The same holds for recovery from a reset in mid-insert, and for changes to `pat_b` and `val_c` after acceptance being visibly ignored at `acc`.

// File: rtl/bitpatch_pkg.sv
package bitpatch_pkg;
   typedef enum logic [2:0] {
      OP_SET    = 3'b000,
      OP_FLIP   = 3'b001,
      OP_CLR    = 3'b010,
      OP_KEEP   = 3'b011,
      OP_DIFF   = 3'b100,
      OP_INSERT = 3'b101,
      OP_RSV6   = 3'b110,
      OP_RSV7   = 3'b111
   } op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_MASK  = 2'd1,
      ST_MERGE = 2'd2
   } st_e;

   typedef enum logic [2:0] {
      ACT_HOLD = 3'd0,
      ACT_OR   = 3'd1,
      ACT_XOR  = 3'd2,
      ACT_ANDN = 3'd3,
      ACT_AND  = 3'd4
   } act_e;
endpackage

// File: rtl/bitpatch_lane.sv
module bitpatch_lane
   import bitpatch_pkg::*;
(
   input  act_e act,
   input  logic cur_bit,
   input  logic ctl_bit,
   output logic nxt_bit
);
   always_comb begin
      case (act)
         ACT_OR:   nxt_bit = cur_bit | ctl_bit;
         ACT_XOR:  nxt_bit = cur_bit ^ ctl_bit;
         ACT_ANDN: nxt_bit = cur_bit & ~ctl_bit;
         ACT_AND:  nxt_bit = cur_bit & ctl_bit;
         default:  nxt_bit = cur_bit;
      endcase
   end
endmodule

// File: rtl/bitpatch_seq.sv
module bitpatch_seq
   import bitpatch_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [2:0]       op_code,
   input  logic [WIDTH-1:0] pat_b,
   input  logic [WIDTH-1:0] val_c,
   output act_e             act,
   output logic [WIDTH-1:0] operand,
   output logic             busy,
   output logic             done
);
   st_e              state_q;
   logic [WIDTH-1:0] hold_b_q;
   logic [WIDTH-1:0] hold_c_q;
   logic             take;
   op_e              op;

   assign op   = op_e'(op_code);
   assign take = start && (state_q == ST_IDLE);
   assign busy = (state_q != ST_IDLE);

   always_comb begin
      act     = ACT_HOLD;
      operand = pat_b;
      case (state_q)
         ST_MASK: begin
            act     = ACT_AND;
            operand = hold_b_q;
         end
         ST_MERGE: begin
            act     = ACT_OR;
            operand = hold_c_q;
         end
         default: begin
            if (take) begin
               case (op)
                  OP_SET:  act = ACT_OR;
                  OP_FLIP: act = ACT_XOR;
                  OP_CLR:  act = ACT_ANDN;
                  OP_KEEP: act = ACT_AND;
                  OP_DIFF: act = ACT_XOR;
                  default: act = ACT_HOLD;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         done     <= 1'b0;
         hold_b_q <= '0;
         hold_c_q <= '0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (take) begin
                  if (op == OP_INSERT) begin
                     state_q  <= ST_MASK;
                     hold_b_q <= pat_b;
                     hold_c_q <= val_c;
                  end else begin
                     done <= 1'b1;
                  end
               end
            end
            ST_MASK:  state_q <= ST_MERGE;
            ST_MERGE: begin
               state_q <= ST_IDLE;
               done    <= 1'b1;
            end
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   // R9: a request during the sequence cannot reorder or stall the steps
   assert_mask_then_merge_R9: assert property (@(posedge clk) disable iff (rst)
      state_q == ST_MASK |=> state_q == ST_MERGE);
   assert_merge_then_idle_R9: assert property (@(posedge clk) disable iff (rst)
      state_q == ST_MERGE |=> (state_q == ST_IDLE && done));
   // R11: completion and activity never overlap
   assert_busy_done_excl_R11: assert property (@(posedge clk) disable iff (rst)
      !(busy && done));
endmodule

// File: rtl/bitpatch_reg.sv
module bitpatch_reg
   import bitpatch_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [2:0]       op_code,
   input  logic [WIDTH-1:0] pat_b,
   input  logic [WIDTH-1:0] val_c,
   output logic [WIDTH-1:0] acc,
   output logic             busy,
   output logic             done
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("bitpatch_reg: WIDTH must be at least 2");
      end
   endgenerate

   act_e           act;
   logic [MSB:0]   operand;
   logic [MSB:0]   acc_nxt;
   logic [MSB:0]   acc_q;

   bitpatch_seq #(.WIDTH(WIDTH)) u_seq (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .op_code (op_code),
      .pat_b   (pat_b),
      .val_c   (val_c),
      .act     (act),
      .operand (operand),
      .busy    (busy),
      .done    (done)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_lane
         bitpatch_lane u_lane (
            .act     (act),
            .cur_bit (acc_q[i]),
            .ctl_bit (operand[i]),
            .nxt_bit (acc_nxt[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) acc_q <= '0;
      else     acc_q <= acc_nxt;
   end

   assign acc = acc_q;

   logic go;
   assign go = start && !busy;

   assert_set_R2: assert property (@(posedge clk) disable iff (rst)
      go && op_code == 3'b000 |=> acc == ($past(acc) | $past(pat_b)));
   assert_flip_R3: assert property (@(posedge clk) disable iff (rst)
      go && op_code == 3'b001 |=> acc == ($past(acc) ^ $past(pat_b)));
   assert_clr_R4: assert property (@(posedge clk) disable iff (rst)
      go && op_code == 3'b010 |=> acc == ($past(acc) & ~$past(pat_b)));
   assert_mask_R5: assert property (@(posedge clk) disable iff (rst)
      go && op_code == 3'b011 |=> acc == ($past(acc) & $past(pat_b)));
   assert_match_R6: assert property (@(posedge clk) disable iff (rst)
      go && op_code == 3'b100 |=> acc == ($past(acc) ^ $past(pat_b)));
   assert_insert_accept_R7: assert property (@(posedge clk) disable iff (rst)
      go && op_code == 3'b101 |=> (busy && $stable(acc)));
   assert_insert_mask_R7: assert property (@(posedge clk) disable iff (rst)
      go && op_code == 3'b101 |-> ##2 (acc == ($past(acc, 2) & $past(pat_b, 2))));
   assert_insert_merge_R8: assert property (@(posedge clk) disable iff (rst)
      go && op_code == 3'b101 |-> ##3 (done && acc == (($past(acc, 3) & $past(pat_b, 3)) | $past(val_c, 3))));
   assert_unknown_op_R10: assert property (@(posedge clk) disable iff (rst)
      go && op_code[2:1] == 2'b11 |=> ($stable(acc) && done));
   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !start && !busy |=> $stable(acc));
endmodule

// File: tb/bitpatch_reg_test.sv
`timescale 1ns/1ps
module bitpatch_reg_test;
   localparam int W = 16;

   typedef struct packed {
      logic [2:0]   op;
      logic [W-1:0] b;
      logic [W-1:0] c;
      logic [W-1:0] mid;
      logic [W-1:0] a_exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{3'b000, 16'hD8B1, 16'h0000, 16'h0000, 16'hD8B1},  // R2
      '{3'b001, 16'h00FF, 16'h0000, 16'h0000, 16'hD84E},  // R3
      '{3'b010, 16'hF000, 16'h0000, 16'h0000, 16'h084E},  // R4
      '{3'b011, 16'h0F0F, 16'h0000, 16'h0000, 16'h080E},  // R5
      '{3'b100, 16'h0A0A, 16'h0000, 16'h0000, 16'h0204},  // R6
      '{3'b000, 16'hD8B1, 16'h0000, 16'h0000, 16'hDAB5},  // R2
      '{3'b010, 16'h0204, 16'h0000, 16'h0000, 16'hD8B1},  // R4
      '{3'b101, 16'hFFF0, 16'h000A, 16'hD8B0, 16'hD8BA},  // R7
      '{3'b110, 16'hFFFF, 16'hFFFF, 16'h0000, 16'hD8BA},  // R10
      '{3'b111, 16'h0000, 16'hFFFF, 16'h0000, 16'hD8BA},  // R10
      '{3'b001, 16'hFFFF, 16'h0000, 16'h0000, 16'h2745},  // R3
      '{3'b100, 16'h2745, 16'h0000, 16'h0000, 16'h0000}   // R6
   };

   logic         clk = 1'b0;
   logic         rst;
   logic         start;
   logic [2:0]   op_code;
   logic [W-1:0] pat_b, val_c, acc;
   logic         busy, done;
   int           n_run = 0;
   int           n_bad = 0;

   always #10 clk = ~clk;

   bitpatch_reg #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .start(start), .op_code(op_code),
      .pat_b(pat_b), .val_c(val_c), .acc(acc), .busy(busy), .done(done)
   );

   task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      rst = 1'b1; start = 1'b0; op_code = '0; pat_b = '0; val_c = '0;
      repeat (3) @(negedge clk);
      chk("R1 acc", acc, 16'h0000);
      chk("R1 busy", {15'b0, busy}, 16'h0);
      chk("R1 done", {15'b0, done}, 16'h0);
      rst = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         start = 1'b1; op_code = VECS[i].op; pat_b = VECS[i].b; val_c = VECS[i].c;
         @(negedge clk);
         start = 1'b0;
         if (VECS[i].op == 3'b101) begin
            chk("R7 busy on accept", {15'b0, busy}, 16'h1);
            @(negedge clk);
            chk("R7 intermediate", acc, VECS[i].mid);
            @(negedge clk);
            chk("R7 busy after merge", {15'b0, busy}, 16'h0);
         end else begin
            chk("R11 busy low", {15'b0, busy}, 16'h0);
         end
         chk("R11 done pulse", {15'b0, done}, 16'h1);
         chk($sformatf("R2-6 vector %0d result", i), acc, VECS[i].a_exp);
         @(negedge clk);
         chk("R11 done single cycle", {15'b0, done}, 16'h0);
      end

      // R11: idle hold
      repeat (4) @(negedge clk);
      chk("R11 hold without start", acc, 16'h0000);

      // build 0xD8BA, then insert with input changes and busy-time requests (R8, R9)
      start = 1'b1; op_code = 3'b000; pat_b = 16'hD8BA;
      @(negedge clk);
      op_code = 3'b101; pat_b = 16'h00FF; val_c = 16'hFF00;
      @(negedge clk);
      chk("R7 acc unchanged on accept", acc, 16'hD8BA);
      op_code = 3'b000; pat_b = 16'hFFFF; val_c = 16'h0000;  // start still high: must be ignored
      @(negedge clk);
      chk("R8 mask uses captured pattern", acc, 16'h00BA);
      @(negedge clk);
      start = 1'b0;
      chk("R9 busy request ignored, R8 merge", acc, 16'hFFBA);
      chk("R7 done after merge", {15'b0, done}, 16'h1);
      @(negedge clk);
      chk("R9 no late action", acc, 16'hFFBA);

      // R1: reset in mid-insert
      start = 1'b1; op_code = 3'b101; pat_b = 16'h0000; val_c = 16'h1234;
      @(negedge clk);
      start = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 reset mid-insert acc", acc, 16'h0000);
      chk("R1 reset mid-insert busy", {15'b0, busy}, 16'h0);
      @(negedge clk);
      @(negedge clk);
      chk("R1 sequence abandoned", acc, 16'h0000);
      chk("R1 no stray done", {15'b0, done}, 16'h0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule